// File: doc/BRIEF.md
# Error-Rate Proportional Supply Voltage Controller

This block closes a supply-voltage loop around a timing-error detector. A pulse on `err_pulse` marks a cycle in which the datapath reported a late-arriving result. The block counts these pulses over a fixed window of `WIN_CYCLES` clocks. At the close of each window it compares the count with a small, nonzero target count. It then moves a digital regulator code by an amount proportional to the difference.

When errors fall short of the target, the circuits have slack to spare, so the code drops. When errors exceed the target, the code rises. Only a proportional term is used. The window should be set to about the regulator's minimum settling time per step, so that a new correction is never issued before the previous one has taken effect.

The code is held between two limits. With the defaults, one LSB is 10 mV, and the range 120 to 180 spans 1.2 V to 1.8 V. Reset parks the code at the top of the range, which is the safest supply.

Top module: `vctl_rate_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following cycle shows `vcode` = CODE_MAX (180 by default) and `vcode_upd` = 0.
- R2: Windows are back-to-back runs of WIN_CYCLES clocks; the first starts at the first edge with `rst_n` high. Each cycle with `err_pulse` high adds one to the count, and every window's count starts from zero.
- R3: The window count saturates at 2^CNT_W-1 (31 by default) and does not wrap.
- R4: `vcode_upd` is high for exactly one cycle per window, in the cycle after the window's last clock edge.
- R5: At an update, the code moves by floor(gain*(count-target)/2^SHIFT), with SHIFT = 2 by default. A count above the target raises the code, and a count below the target lowers it.
- R6: A window whose count equals the target leaves `vcode` unchanged.
- R7: After the step is applied, the result is clamped to [CODE_MIN, CODE_MAX], which is [120, 180] by default.
- R8: `vcode` changes only in cycles where `vcode_upd` is high.
- R9: `target_cnt` and `gain` are sampled only in the last cycle of a window. Their values in the window's other cycles have no effect on that window's update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_pulse | input | 1 | One timing-error event in this cycle |
| target_cnt | input | CNT_W | Desired error count per window |
| gain | input | GAIN_W | Proportional gain, unsigned |
| vcode | output | CODE_W | Regulator voltage code |
| vcode_upd | output | 1 | One-cycle strobe marking a new code |

## Verification
The hardest case to reach from the ports is the interplay of saturation and sampling time. A window that hits the counter ceiling looks from outside like an ordinary large step. A change to gain or target inside a window is invisible unless the values in force at the close differ from the early ones.

The stimulus places error pulses at exact positions that are aligned to the window grid. It fills one entire window with errors, so that the unsaturated count of 64 and the saturated count of 31 give different codes. It drives one gain and target for most of another window and a different pair in its final cycle. A behavioural model tracks every cycle, and the update codes are also compared against hand-computed values.

// File: rtl/vctl_pkg.sv
// Package: shared arithmetic type and clamp helper for the voltage controller.
// Assumes every intermediate value (count, gain product, code sum) fits in 32 signed bits.
package vctl_pkg;

    typedef logic signed [31:0] vctl_acc_t;

    // Limit a signed value to the closed range [lo, hi].
    function automatic vctl_acc_t vctl_clamp(input vctl_acc_t v, input vctl_acc_t lo,
                                             input vctl_acc_t hi);
        if (v < lo)
            return lo;
        if (v > hi)
            return hi;
        return v;
    endfunction

endpackage

// File: rtl/vctl_window.sv
// Window timer: counts WIN_CYCLES clocks and flags the last cycle of each window.
// Assumes WIN_CYCLES >= 2. The first window begins at the first edge after reset release.
module vctl_window #(
    parameter int WIN_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_last
);
    localparam int WIN_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_CYCLES - 1);

    logic [WIN_W-1:0] pos_q;

    // Position inside the current window, wrapping after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (pos_q == LAST)
            pos_q <= '0;
        else
            pos_q <= pos_q + 1'b1;
    end

    assign win_last = (pos_q == LAST);

    // R2: after the final cycle the next window starts from position zero
    a_r2_window_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        win_last |=> (pos_q == '0));

    // R4: the closing cycle is a single cycle, never two in a row
    a_r4_close_single: assert property (@(posedge clk) disable iff (!rst_n)
        win_last |=> !win_last);

endmodule

// File: rtl/vctl_err_count.sv
// Saturating error counter: accumulates err_pulse over a window and latches the
// final count (including the closing cycle) when win_last is high, then restarts at zero.
// Assumes err_pulse is synchronous to clk.
module vctl_err_count #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_pulse,
    input  logic             win_last,
    output logic [CNT_W-1:0] samp_cnt,
    output logic             samp_vld
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    // Count including this cycle's pulse, held at the ceiling.
    always_comb begin
        if (err_pulse && (cnt_q != SAT))
            cnt_inc = cnt_q + 1'b1;
        else
            cnt_inc = cnt_q;
    end

    // Running count; cleared when a window closes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (win_last)
            cnt_q <= '0;
        else
            cnt_q <= cnt_inc;
    end

    // Latch the closed window's count and raise a one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_cnt <= '0;
            samp_vld <= 1'b0;
        end else begin
            samp_vld <= win_last;
            if (win_last)
                samp_cnt <= cnt_inc;
        end
    end

    // R3: a saturated count stays saturated until the window closes
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == SAT && !win_last) |=> (cnt_q == SAT));

    // R2: every window's count starts from zero
    a_r2_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        win_last |=> (cnt_q == '0));

    // R3: the count never decreases inside a window
    a_r3_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !win_last |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/vctl_step.sv
// Proportional step and clamp: captures target and gain in the closing cycle, and on the
// following cycle adds floor(gain*(count-target)/2^SHIFT) to the code, clamped to range.
// Assumes CNT_W + GAIN_W + CODE_W stays well below 30 so 32-bit arithmetic cannot overflow.
module vctl_step
    import vctl_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int GAIN_W   = 4,
    parameter int CODE_W   = 8,
    parameter int SHIFT    = 2,
    parameter int CODE_MIN = 120,
    parameter int CODE_MAX = 180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_last,
    input  logic [CNT_W-1:0]  target_cnt,
    input  logic [GAIN_W-1:0] gain,
    input  logic [CNT_W-1:0]  samp_cnt,
    input  logic              samp_vld,
    output logic [CODE_W-1:0] vcode,
    output logic              vcode_upd
);
    localparam vctl_acc_t LO = vctl_acc_t'(CODE_MIN);
    localparam vctl_acc_t HI = vctl_acc_t'(CODE_MAX);

    logic [CNT_W-1:0]  tgt_q;
    logic [GAIN_W-1:0] gain_q;
    vctl_acc_t         diff;
    vctl_acc_t         prod;
    vctl_acc_t         stepv;
    vctl_acc_t         nxt;

    // Capture target and gain only in the closing cycle of a window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            gain_q <= '0;
        end else if (win_last) begin
            tgt_q  <= target_cnt;
            gain_q <= gain;
        end
    end

    // Signed error, proportional product, arithmetic shift (floor), clamped sum.
    always_comb begin
        diff  = vctl_acc_t'(32'(samp_cnt)) - vctl_acc_t'(32'(tgt_q));
        prod  = diff * vctl_acc_t'(32'(gain_q));
        stepv = prod >>> SHIFT;
        nxt   = vctl_clamp(vctl_acc_t'(32'(vcode)) + stepv, LO, HI);
    end

    // Code register and update strobe; the code moves only with the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcode     <= CODE_W'(CODE_MAX);
            vcode_upd <= 1'b0;
        end else begin
            vcode_upd <= samp_vld;
            if (samp_vld)
                vcode <= CODE_W'(nxt);
        end
    end

    // R6: a window whose count equals the target leaves the code unchanged
    a_r6_on_target_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_vld && samp_cnt == tgt_q) |=> $stable(vcode));

    // R5: above target never lowers the code
    a_r5_raise_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_vld && samp_cnt > tgt_q) |=> (vcode >= $past(vcode)));

    // R5: below target never raises the code
    a_r5_lower_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_vld && samp_cnt < tgt_q) |=> (vcode <= $past(vcode)));

endmodule

// File: rtl/vctl_rate_ctrl.sv
// Top: error-rate proportional voltage controller. Counts timing errors per window,
// compares against a target at the window close, and steps a clamped regulator code.
// Assumes WIN_CYCLES is about the regulator's minimum step settling time.
module vctl_rate_ctrl #(
    parameter int WIN_CYCLES = 64,
    parameter int CNT_W      = 5,
    parameter int GAIN_W     = 4,
    parameter int CODE_W     = 8,
    parameter int SHIFT      = 2,
    parameter int CODE_MIN   = 120,
    parameter int CODE_MAX   = 180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_pulse,
    input  logic [CNT_W-1:0]  target_cnt,
    input  logic [GAIN_W-1:0] gain,
    output logic [CODE_W-1:0] vcode,
    output logic              vcode_upd
);
    logic             win_last;
    logic [CNT_W-1:0] samp_cnt;
    logic             samp_vld;

    vctl_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_last (win_last)
    );

    vctl_err_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_pulse (err_pulse),
        .win_last  (win_last),
        .samp_cnt  (samp_cnt),
        .samp_vld  (samp_vld)
    );

    vctl_step #(
        .CNT_W    (CNT_W),
        .GAIN_W   (GAIN_W),
        .CODE_W   (CODE_W),
        .SHIFT    (SHIFT),
        .CODE_MIN (CODE_MIN),
        .CODE_MAX (CODE_MAX)
    ) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_last   (win_last),
        .target_cnt (target_cnt),
        .gain       (gain),
        .samp_cnt   (samp_cnt),
        .samp_vld   (samp_vld),
        .vcode      (vcode),
        .vcode_upd  (vcode_upd)
    );

    // R1: a reset edge leaves the code at the maximum and no strobe
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (vcode == CODE_W'(CODE_MAX) && !vcode_upd));

    // R7: the code stays inside the allowed range
    a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (vcode >= CODE_W'(CODE_MIN)) && (vcode <= CODE_W'(CODE_MAX)));

    // R8: without a strobe the code holds its value
    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !vcode_upd |-> $stable(vcode));

    // R4: the strobe lasts a single cycle
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        vcode_upd |=> !vcode_upd);

endmodule

// File: tb/vctl_rate_ctrl_tb.sv
// Bench: behavioural cycle model compared on every falling edge, plus directed update values.
module vctl_rate_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WIN   = 64;
    localparam int CNT_W = 5;
    localparam int GW    = 4;
    localparam int SH    = 2;
    localparam int CMIN  = 120;
    localparam int CMAX  = 180;
    localparam int SAT   = 31;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          err_pulse = 1'b0;
    logic [CNT_W-1:0] target_cnt = '0;
    logic [GW-1:0] gain = '0;
    logic [7:0]    vcode;
    logic          vcode_upd;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string tag = "R1";
    int upd_log[$];

    // reference model state
    int m_pos = 0, m_errs = 0, m_pend = 0, m_cnt = 0, m_tgt = 0, m_gain = 0;
    int exp_code = CMAX;
    int exp_upd = 0;
    int edges = 0;

    vctl_rate_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse),
        .target_cnt(target_cnt), .gain(gain),
        .vcode(vcode), .vcode_upd(vcode_upd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference, advanced at each rising edge
    always @(posedge clk) begin
        int e, s, v;
        edges++;
        if (!rst_n) begin
            m_pos = 0; m_errs = 0; m_pend = 0; exp_code = CMAX; exp_upd = 0;
        end else begin
            exp_upd = 0;
            if (m_pend != 0) begin
                s = (m_gain * (m_cnt - m_tgt)) >>> SH;
                v = exp_code + s;
                if (v < CMIN) v = CMIN;
                if (v > CMAX) v = CMAX;
                exp_code = v;
                exp_upd = 1;
                m_pend = 0;
            end
            e = m_errs + (err_pulse ? 1 : 0);
            if (e > SAT) e = SAT;
            if (m_pos == WIN - 1) begin
                m_cnt = e; m_tgt = int'(target_cnt); m_gain = int'(gain);
                m_pend = 1; m_errs = 0; m_pos = 0;
            end else begin
                m_errs = e; m_pos++;
            end
        end
    end

    // compare outputs with the model away from the active edge
    always @(negedge clk) begin
        if (edges > 0) begin
            total++;
            if (int'(vcode) != exp_code) begin
                bad++;
                $display("FAIL %s vcode actual=%0d expected=%0d", exp_upd ? tag : "R8",
                         vcode, exp_code);
            end
            total++;
            if (int'(vcode_upd) != exp_upd) begin
                bad++;
                $display("FAIL R4 vcode_upd actual=%0d expected=%0d", vcode_upd, exp_upd);
            end
            if (vcode_upd) upd_log.push_back(int'(vcode));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check_val(input string rq, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
        end
    endtask

    // One aligned window: n errors placed at its end; target/gain switch in the last cycle.
    task automatic run_window(input string t, input int n, input int tg_e, input int gn_e,
                              input int tg_l, input int gn_l);
        tag = t;
        for (int i = 0; i < WIN; i++) begin
            err_pulse  = (i >= WIN - n);
            target_cnt = CNT_W'((i == WIN - 1) ? tg_l : tg_e);
            gain       = GW'((i == WIN - 1) ? gn_l : gn_e);
            @(negedge clk);
        end
    endtask

    task automatic run_random(input string t);
        tag = t;
        target_cnt = CNT_W'($urandom_range(0, 15));
        gain = GW'($urandom_range(0, 15));
        for (int i = 0; i < WIN; i++) begin
            err_pulse = ($urandom_range(0, 7) == 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_val("R1 reset vcode", int'(vcode), CMAX);
        check_val("R1 reset strobe", int'(vcode_upd), 0);
        rst_n = 1'b1;
        run_window("R5", 0, 4, 8, 4, 8);        // 180 - 8 = 172
        run_window("R7", 0, 31, 15, 31, 15);    // clamp low: 120
        run_window("R5", 10, 2, 2, 2, 2);       // +4 -> 124
        run_window("R6", 5, 5, 15, 5, 15);      // on target -> 124
        run_window("R3", 64, 0, 1, 0, 1);       // saturates at 31: +7 -> 131
        run_window("R5", 3, 4, 1, 4, 1);        // floor(-1/4) = -1 -> 130
        run_window("R9", 6, 31, 15, 2, 4);      // last-cycle values used: +4 -> 134
        run_window("R7", 64, 0, 15, 0, 15);     // clamp high: 180
        for (int k = 0; k < 6; k++) run_random("R2");
        // reset in mid-window
        run_window("R1", 0, 0, 0, 0, 0);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_val("R1 mid reset vcode", int'(vcode), CMAX);
        check_val("R1 mid reset strobe", int'(vcode_upd), 0);
        rst_n = 1'b1;
        run_window("R5", 0, 8, 4, 8, 4);        // 180 - 8 = 172
        run_window("R2", 0, 0, 0, 0, 0);
        check_val("R4 update count", upd_log.size() >= 8 ? 1 : 0, 1);
        if (upd_log.size() >= 8) begin
            check_val("R5 below target lowers", upd_log[0], 172);
            check_val("R7 clamp at minimum", upd_log[1], 120);
            check_val("R5 above target raises", upd_log[2], 124);
            check_val("R6 on target holds", upd_log[3], 124);
            check_val("R3 saturated count", upd_log[4], 131);
            check_val("R5 floor rounding", upd_log[5], 130);
            check_val("R9 last cycle sampling", upd_log[6], 134);
            check_val("R7 clamp at maximum", upd_log[7], 180);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule